// File: doc/BRIEF.md
# Dual-Mode Burst Address Generator

This block supplies the low-order address bits of a four-beat burst for a synchronous memory front end. When an access starts, a load strobe captures a two-bit start offset and the order select. After that, each cycle with the active-low advance input asserted moves the burst one beat on. With advance inactive the current beat is held, which lets a controller insert wait states.

There are two burst orders. In interleaved order, beat n goes to the start offset XOR n. In linear order, beat n goes to the start offset plus n, modulo four. The order is captured at load time, so a change on the select input during a burst has no effect until the next load. The beat index is also an output, so the surrounding logic can count the beats it has transferred.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets both addr_o and beat_o to 0 from the next cycle.
- R2: A cycle with load_i high makes addr_o equal to start_i and beat_o equal to 0 from the next cycle.
- R3: adv_n_i has no effect in a cycle with load_i high. The state after the load is the same whether adv_n_i is 0 or 1.
- R4: With mode_i high when captured by the load (interleaved), addr_o equals start XOR beat_o. Examples: start 2 gives 2,3,0,1 and start 3 gives 3,2,1,0.
- R5: With mode_i low when captured by the load (linear), addr_o equals (start + beat_o) mod 4. Example: start 1 gives 1,2,3,0.
- R6: In a cycle with load_i low and adv_n_i high, addr_o and beat_o keep their values (burst suspended).
- R7: mode_i is sampled only in load cycles. Changing it between loads does not alter the order of the running burst.
- R8: After the fourth beat, beat_o wraps from 3 to 0 and addr_o returns to the start offset. Further advances repeat the same four addresses.
- R9: In a cycle with load_i low and adv_n_i low, beat_o increases by exactly 1 (mod 4) at the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Start a new burst from start_i |
| start_i | input | 2 | Start offset (low address bits) |
| adv_n_i | input | 1 | Advance, active low |
| mode_i | input | 1 | Order select: 1 interleaved, 0 linear |
| addr_o | output | 2 | Current burst address bits |
| beat_o | output | 2 | Current beat index |

## Verification
The bench covers every start offset in both orders, under advance patterns that mix steps and stalls.

- A design that honoured advance during a load would start the burst on beat 1 and skip the first address.
- A design that decoded the order from the live mode_i would jump between sequences when mode_i toggles mid-burst.
- A design that let the index saturate instead of wrapping would stall on the last address instead of repeating the sequence.
- A design that swapped the XOR and add rules would differ at starts 1 and 3, where the two orders diverge.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] start_i,
  input  logic          adv_n_i,
  input  logic          mode_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] beat_o
);

  logic [AW-1:0] base_q;
  logic [AW-1:0] idx_q;
  logic          ilv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      idx_q  <= '0;
      ilv_q  <= 1'b0;
    end else if (load_i) begin
      base_q <= start_i;
      idx_q  <= '0;
      ilv_q  <= mode_i;
    end else if (!adv_n_i) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign addr_o = ilv_q ? (base_q ^ idx_q) : (base_q + idx_q);
  assign beat_o = idx_q;

endmodule

module burst_addr_gen_chk #(
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          load_i,
  input logic [AW-1:0] start_i,
  input logic          adv_n_i,
  input logic [AW-1:0] addr_o,
  input logic [AW-1:0] beat_o
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && beat_o == '0));

  p_load_start_r2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (addr_o == $past(start_i) && beat_o == '0));

  p_hold_stall_r6: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_n_i) |=> ($stable(addr_o) && $stable(beat_o)));

  p_step_one_r9: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i) |=> (beat_o == ($past(beat_o) + 1'b1)));

  p_wrap_home_r8: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i && beat_o == '1) |=> (beat_o == '0));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .load_i(load_i), .start_i(start_i),
  .adv_n_i(adv_n_i), .addr_o(addr_o), .beat_o(beat_o)
);

// File: tb/burst_addr_gen_tb_top.sv
`timescale 1ns/100ps
module burst_addr_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_i = 1'b0;
  logic [1:0] start_i = 2'd0;
  logic       adv_n_i = 1'b1;
  logic       mode_i = 1'b0;
  logic [1:0] addr_o, beat_o;

  int nvec = 0;
  int nerr = 0;
  logic [1:0] m_start, m_idx;
  logic       m_ilv;

  always #2.5 clk = ~clk;

  burst_addr_gen dut_i (
    .clk(clk), .rst(rst), .load_i(load_i), .start_i(start_i),
    .adv_n_i(adv_n_i), .mode_i(mode_i), .addr_o(addr_o), .beat_o(beat_o)
  );

  task automatic check(input string tag, input logic [1:0] a_exp, input logic [1:0] b_exp);
    nvec++;
    if (addr_o !== a_exp || beat_o !== b_exp) begin
      nerr++;
      $display("FAIL %s: addr=%0d beat=%0d expected addr=%0d beat=%0d",
               tag, addr_o, beat_o, a_exp, b_exp);
    end
  endtask

  function automatic logic [1:0] exp_addr();
    return m_ilv ? (m_start ^ m_idx) : (m_start + m_idx);
  endfunction

  task automatic step(input logic ld, input logic [1:0] st, input logic an, input logic md);
    string tag;
    @(negedge clk);
    load_i = ld; start_i = st; adv_n_i = an; mode_i = md;
    @(posedge clk);
    #1;
    if (ld) begin
      m_start = st; m_idx = 2'd0; m_ilv = md;
      tag = an ? "R2" : "R3";
    end else if (!an) begin
      m_idx = m_idx + 2'd1;
      if (m_idx == 2'd0) tag = "R8";
      else if (md != m_ilv) tag = "R7";
      else tag = m_ilv ? "R4" : "R5";
    end else begin
      tag = "R6";
    end
    check(tag, exp_addr(), m_idx);
    if (!ld && !an) check("R9", exp_addr(), m_idx);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; load_i = 1'b0; adv_n_i = 1'b0;
    @(posedge clk);
    #1;
    rst = 1'b0;
    m_start = 2'd0; m_idx = 2'd0; m_ilv = 1'b0;
    check("R1", 2'd0, 2'd0);
  endtask

  initial begin
    #(200000 * 5);
    nerr++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [7:0] pat;
    do_reset();
    for (int md = 0; md < 2; md++) begin
      for (int st = 0; st < 4; st++) begin
        for (int p = 0; p < 6; p++) begin
          case (p)
            0: pat = 8'h00;
            1: pat = 8'hAA;
            2: pat = 8'h55;
            3: pat = 8'hCC;
            4: pat = 8'hF0;
            default: pat = 8'h39;
          endcase
          step(1'b1, 2'(st), pat[0], md[0]);
          for (int k = 1; k < 8; k++)
            step(1'b0, 2'(st + k), pat[k], (p > 2) ? ~md[0] : md[0]);
          for (int k = 0; k < 5; k++)
            step(1'b0, 2'(k), 1'b0, k[0]);
        end
      end
      do_reset();
    end
    step(1'b1, 2'd3, 1'b0, 1'b1);
    step(1'b0, 2'd0, 1'b0, 1'b1);
    do_reset();
    check("R1", 2'd0, 2'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule